// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block turns a decoded operand addressing mode into a memory address. It takes the current base pointers (BX, BP), the index pointers (SI, DI), a displacement, and the four segment register values. From these it forms a 16-bit effective offset, picks the segment that qualifies it, and builds the 20-bit physical address. The physical address is the segment value times sixteen plus the offset.

A decode stage presents one request per cycle with `in_valid` high. The result appears on the registered outputs in the next cycle with `out_valid` high. The selected segment follows from the pointer the mode uses: any mode that involves BP defaults to the stack segment, and every other mode defaults to the data segment. An explicit override can name any of the four segments instead. A displacement is either a full 16-bit word or a short byte that is sign-extended before the add.

Top module: `seg_addr_gen`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low after each cycle in which `in_valid` is low. Reset clears `out_valid`, `eff_off`, `seg_id` and `phys_addr` to zero.
- R2: `mode` 0 (direct) yields an offset equal to the full 16-bit `disp`, whatever the value of `disp_wide`. The unused codes 5, 6 and 7 behave as direct.
- R3: `mode` 1 (register indirect) yields the pointer chosen by `ptr_sel`: 0 = BX, 1 = BP, 2 = SI, 3 = DI.
- R4: `mode` 2 (register relative) yields the `ptr_sel` pointer plus the extended displacement.
- R5: With `disp_wide` = 0, the displacement used is `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` has no effect. With `disp_wide` = 1, all 16 bits are used.
- R6: `mode` 3 (based indexed) yields the base plus the index. `base_sel` picks the base (0 = BX, 1 = BP) and `idx_sel` picks the index (0 = SI, 1 = DI).
- R7: `mode` 4 (based indexed with displacement) yields base plus index plus the extended displacement.
- R8: Every offset sum wraps modulo 2^16.
- R9: When `ovr_en` is 0, `seg_id` is 2 (SS) for any mode that uses BP, and 3 (DS) for every other mode, including direct. Segment codes are 0 = ES, 1 = CS, 2 = SS, 3 = DS.
- R10: When `ovr_en` is 1, `seg_id` equals `ovr_seg`, whatever the mode.
- R11: `phys_addr` equals the value of the segment selected by `seg_id` times 16, plus `eff_off`, modulo 2^20. For example, DS = 5000h with a direct offset of 4321h gives 54321h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Single-pointer select for modes 1 and 2 |
| base_sel | input | 1 | Base select for modes 3 and 4 |
| idx_sel | input | 1 | Index select for modes 3 and 4 |
| disp | input | 16 | Displacement word or byte |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = sign-extended byte |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment code |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| out_valid | output | 1 | Result valid |
| eff_off | output | 16 | Effective offset |
| seg_id | output | 2 | Selected segment code |
| phys_addr | output | 20 | Physical address |

## Verification
The block has only one stage of state, so any fault shows at the ports in the cycle right after the strobe. A wrong pointer or displacement selection shows as a wrong `eff_off`. A faulty default or override choice shows as a wrong `seg_id`. A faulty shift or carry shows as a `phys_addr` that disagrees with the segment and offset beside it. The random vectors cover every mode, select and override combination. Directed vectors force the carry out of the offset adder, the 20-bit wrap, and short displacements whose high byte is filled with junk.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
   typedef enum logic [2:0] {
      AM_DIRECT        = 3'd0,
      AM_PTR           = 3'd1,
      AM_PTR_DISP      = 3'd2,
      AM_BASE_IDX      = 3'd3,
      AM_BASE_IDX_DISP = 3'd4
   } amode_e;

   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_e;

   localparam logic [1:0] PTR_BX = 2'd0;
   localparam logic [1:0] PTR_BP = 2'd1;
   localparam logic [1:0] PTR_SI = 2'd2;
   localparam logic [1:0] PTR_DI = 2'd3;
endpackage

// File: rtl/seg_addr_offset.sv
module seg_addr_offset
   import seg_addr_pkg::*;
#(
   parameter int OFF_W    = 16,
   parameter int SHORT_W  = 8,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [2:0]       mode,
   input  logic [1:0]       ptr_sel,
   input  logic             base_sel,
   input  logic             idx_sel,
   input  logic [OFF_W-1:0] disp,
   input  logic             disp_wide,
   input  logic [OFF_W-1:0] reg_bx,
   input  logic [OFF_W-1:0] reg_bp,
   input  logic [OFF_W-1:0] reg_si,
   input  logic [OFF_W-1:0] reg_di,
   output logic [OFF_W-1:0] off,
   output logic             uses_bp
);
   localparam int PAD_W = OFF_W - SHORT_W;

   logic [OFF_W-1:0] short_ext;
   logic [OFF_W-1:0] disp_ext;
   logic [OFF_W-1:0] ptr_val;
   logic [OFF_W-1:0] base_val;
   logic [OFF_W-1:0] idx_val;
   logic [OFF_W-1:0] pair_sum;

   generate
      if (SIGN_EXT) begin : g_sext
         assign short_ext = {{PAD_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      end else begin : g_zext
         assign short_ext = {{PAD_W{1'b0}}, disp[SHORT_W-1:0]};
      end
   endgenerate

   assign disp_ext = disp_wide ? disp : short_ext;

   always_comb begin
      case (ptr_sel)
         PTR_BX:  ptr_val = reg_bx;
         PTR_BP:  ptr_val = reg_bp;
         PTR_SI:  ptr_val = reg_si;
         default: ptr_val = reg_di;
      endcase
   end

   assign base_val = base_sel ? reg_bp : reg_bx;
   assign idx_val  = idx_sel  ? reg_di : reg_si;
   assign pair_sum = base_val + idx_val;

   always_comb begin
      off     = disp;
      uses_bp = 1'b0;
      case (amode_e'(mode))
         AM_PTR: begin
            off     = ptr_val;
            uses_bp = (ptr_sel == PTR_BP);
         end
         AM_PTR_DISP: begin
            off     = ptr_val + disp_ext;
            uses_bp = (ptr_sel == PTR_BP);
         end
         AM_BASE_IDX: begin
            off     = pair_sum;
            uses_bp = base_sel;
         end
         AM_BASE_IDX_DISP: begin
            off     = pair_sum + disp_ext;
            uses_bp = base_sel;
         end
         default: begin
            off     = disp;
            uses_bp = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/seg_addr_segsel.sv
module seg_addr_segsel
   import seg_addr_pkg::*;
#(
   parameter int SEG_W  = 16,
   parameter int N_SEGS = 4
) (
   input  logic             uses_bp,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   input  logic [SEG_W-1:0] seg_es,
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_ds,
   output logic [1:0]       seg_code,
   output logic [SEG_W-1:0] seg_val
);
   logic [SEG_W-1:0] seg_in  [N_SEGS];
   logic [SEG_W-1:0] seg_tab [N_SEGS];

   assign seg_in[SEG_ES] = seg_es;
   assign seg_in[SEG_CS] = seg_cs;
   assign seg_in[SEG_SS] = seg_ss;
   assign seg_in[SEG_DS] = seg_ds;

   genvar gi;
   generate
      for (gi = 0; gi < N_SEGS; gi++) begin : g_tab
         assign seg_tab[gi] = seg_in[gi];
      end
   endgenerate

   always_comb begin
      if (ovr_en)       seg_code = ovr_seg;
      else if (uses_bp) seg_code = SEG_SS;
      else              seg_code = SEG_DS;
   end

   assign seg_val = seg_tab[seg_code];
endmodule

// File: rtl/seg_addr_phys.sv
module seg_addr_phys #(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   localparam int PA_W     = OFF_W + SEG_SHIFT
) (
   input  logic [OFF_W-1:0] seg_val,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa
);
   generate
      if (SEG_SHIFT > 0) begin : g_shift
         assign pa = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
      end else begin : g_flat
         assign pa = seg_val + off;
      end
   endgenerate
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int OFF_W     = 16,
   parameter int SHORT_W   = 8,
   parameter int SEG_SHIFT = 4,
   parameter bit SIGN_EXT  = 1'b1,
   localparam int PA_W     = OFF_W + SEG_SHIFT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [2:0]       mode,
   input  logic [1:0]       ptr_sel,
   input  logic             base_sel,
   input  logic             idx_sel,
   input  logic [OFF_W-1:0] disp,
   input  logic             disp_wide,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   input  logic [OFF_W-1:0] reg_bx,
   input  logic [OFF_W-1:0] reg_bp,
   input  logic [OFF_W-1:0] reg_si,
   input  logic [OFF_W-1:0] reg_di,
   input  logic [OFF_W-1:0] seg_es,
   input  logic [OFF_W-1:0] seg_cs,
   input  logic [OFF_W-1:0] seg_ss,
   input  logic [OFF_W-1:0] seg_ds,
   output logic             out_valid,
   output logic [OFF_W-1:0] eff_off,
   output logic [1:0]       seg_id,
   output logic [PA_W-1:0]  phys_addr
);
   generate
      if (SHORT_W < 1 || SHORT_W >= OFF_W) begin : g_bad_short
         $error("SHORT_W must lie between 1 and OFF_W-1");
      end
      if (SEG_SHIFT < 0 || SEG_SHIFT > OFF_W) begin : g_bad_shift
         $error("SEG_SHIFT out of range");
      end
   endgenerate

   logic [OFF_W-1:0] off_c;
   logic             uses_bp_c;
   logic [1:0]       seg_code_c;
   logic [OFF_W-1:0] seg_val_c;
   logic [PA_W-1:0]  pa_c;

   seg_addr_offset #(
      .OFF_W    (OFF_W),
      .SHORT_W  (SHORT_W),
      .SIGN_EXT (SIGN_EXT)
   ) u_offset (
      .mode      (mode),
      .ptr_sel   (ptr_sel),
      .base_sel  (base_sel),
      .idx_sel   (idx_sel),
      .disp      (disp),
      .disp_wide (disp_wide),
      .reg_bx    (reg_bx),
      .reg_bp    (reg_bp),
      .reg_si    (reg_si),
      .reg_di    (reg_di),
      .off       (off_c),
      .uses_bp   (uses_bp_c)
   );

   seg_addr_segsel #(
      .SEG_W  (OFF_W),
      .N_SEGS (4)
   ) u_segsel (
      .uses_bp  (uses_bp_c),
      .ovr_en   (ovr_en),
      .ovr_seg  (ovr_seg),
      .seg_es   (seg_es),
      .seg_cs   (seg_cs),
      .seg_ss   (seg_ss),
      .seg_ds   (seg_ds),
      .seg_code (seg_code_c),
      .seg_val  (seg_val_c)
   );

   seg_addr_phys #(
      .OFF_W     (OFF_W),
      .SEG_SHIFT (SEG_SHIFT)
   ) u_phys (
      .seg_val (seg_val_c),
      .off     (off_c),
      .pa      (pa_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         eff_off   <= '0;
         seg_id    <= 2'd0;
         phys_addr <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            eff_off   <= off_c;
            seg_id    <= seg_code_c;
            phys_addr <= pa_c;
         end
      end
   end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   localparam int PA_W     = OFF_W + SEG_SHIFT
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [2:0]       mode,
   input logic [1:0]       ptr_sel,
   input logic             base_sel,
   input logic             ovr_en,
   input logic [1:0]       ovr_seg,
   input logic [OFF_W-1:0] disp,
   input logic [OFF_W-1:0] reg_bx,
   input logic [OFF_W-1:0] reg_bp,
   input logic [OFF_W-1:0] reg_si,
   input logic [OFF_W-1:0] reg_di,
   input logic [OFF_W-1:0] seg_es,
   input logic [OFF_W-1:0] seg_cs,
   input logic [OFF_W-1:0] seg_ss,
   input logic [OFF_W-1:0] seg_ds,
   input logic             out_valid,
   input logic [OFF_W-1:0] eff_off,
   input logic [1:0]       seg_id,
   input logic [PA_W-1:0]  phys_addr
);
   function automatic logic [OFF_W-1:0] pick4(input logic [1:0] s,
      input logic [OFF_W-1:0] a, input logic [OFF_W-1:0] b,
      input logic [OFF_W-1:0] c, input logic [OFF_W-1:0] d);
      case (s)
         2'd0:    return a;
         2'd1:    return b;
         2'd2:    return c;
         default: return d;
      endcase
   endfunction

   logic bp_mode;
   logic is_direct;
   assign bp_mode = ((mode == 3'd1 || mode == 3'd2) && ptr_sel == 2'd1) ||
                    ((mode == 3'd3 || mode == 3'd4) && base_sel);
   assign is_direct = (mode == 3'd0) || (mode > 3'd4);

   AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R1
   AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R1
   AST_DIRECT_OFF: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_direct) |=> eff_off == $past(disp)); // R2
   AST_PTR_OFF: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 3'd1) |=>
         eff_off == $past(pick4(ptr_sel, reg_bx, reg_bp, reg_si, reg_di))); // R3
   AST_STACK_DEFAULT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ovr_en && bp_mode) |=> seg_id == 2'd2); // R9
   AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ovr_en && !bp_mode) |=> seg_id == 2'd3); // R9
   AST_OVERRIDE_SEG: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ovr_en) |=> seg_id == $past(ovr_seg)); // R10
   AST_PHYS_COMPOSE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> phys_addr ==
         ({pick4(seg_id, $past(seg_es), $past(seg_cs), $past(seg_ss), $past(seg_ds)),
           {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, eff_off})); // R11
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
   .OFF_W     (OFF_W),
   .SEG_SHIFT (SEG_SHIFT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .mode      (mode),
   .ptr_sel   (ptr_sel),
   .base_sel  (base_sel),
   .ovr_en    (ovr_en),
   .ovr_seg   (ovr_seg),
   .disp      (disp),
   .reg_bx    (reg_bx),
   .reg_bp    (reg_bp),
   .reg_si    (reg_si),
   .reg_di    (reg_di),
   .seg_es    (seg_es),
   .seg_cs    (seg_cs),
   .seg_ss    (seg_ss),
   .seg_ds    (seg_ds),
   .out_valid (out_valid),
   .eff_off   (eff_off),
   .seg_id    (seg_id),
   .phys_addr (phys_addr)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  ptr_sel = '0;
   logic        base_sel = 1'b0;
   logic        idx_sel = 1'b0;
   logic [15:0] disp = '0;
   logic        disp_wide = 1'b0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_seg = '0;
   logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
   logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
   logic        out_valid;
   logic [15:0] eff_off;
   logic [1:0]  seg_id;
   logic [19:0] phys_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   seg_addr_gen u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
      .ptr_sel(ptr_sel), .base_sel(base_sel), .idx_sel(idx_sel),
      .disp(disp), .disp_wide(disp_wide), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
      .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .out_valid(out_valid), .eff_off(eff_off), .seg_id(seg_id),
      .phys_addr(phys_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ext_disp();
      return disp_wide ? disp : {{8{disp[7]}}, disp[7:0]};
   endfunction

   function automatic logic [15:0] ptr_value();
      case (ptr_sel)
         2'd0: return reg_bx;
         2'd1: return reg_bp;
         2'd2: return reg_si;
         default: return reg_di;
      endcase
   endfunction

   function automatic logic [15:0] exp_off();
      logic [15:0] pair;
      pair = (base_sel ? reg_bp : reg_bx) + (idx_sel ? reg_di : reg_si);
      case (mode)
         3'd1: return ptr_value();
         3'd2: return ptr_value() + ext_disp();
         3'd3: return pair;
         3'd4: return pair + ext_disp();
         default: return disp;
      endcase
   endfunction

   function automatic logic [1:0] exp_seg();
      logic bp;
      bp = ((mode == 3'd1 || mode == 3'd2) && ptr_sel == 2'd1) ||
           ((mode == 3'd3 || mode == 3'd4) && base_sel);
      if (ovr_en) return ovr_seg;
      return bp ? 2'd2 : 2'd3;
   endfunction

   function automatic logic [19:0] exp_pa(input logic [1:0] s, input logic [15:0] o);
      logic [15:0] sv;
      case (s)
         2'd0: sv = seg_es;
         2'd1: sv = seg_cs;
         2'd2: sv = seg_ss;
         default: sv = seg_ds;
      endcase
      return {sv, 4'h0} + {4'h0, o};
   endfunction

   function automatic string mode_tag();
      case (mode)
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R6";
         3'd4: return "R7";
         default: return "R2";
      endcase
   endfunction

   // Inputs are set at a falling edge; the result is sampled one falling edge later.
   task automatic apply(input string otag);
      logic [15:0] eo;
      logic [1:0]  es;
      logic [19:0] ep;
      eo = exp_off(); es = exp_seg(); ep = exp_pa(es, eo);
      in_valid = 1'b1;
      @(negedge clk);
      chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
      chk(otag, {16'd0, eff_off}, {16'd0, eo});
      chk(ovr_en ? "R10 seg" : "R9 seg", {30'd0, seg_id}, {30'd0, es});
      chk("R11 phys", {12'd0, phys_addr}, {12'd0, ep});
   endtask

   task automatic idle();
      in_valid = 1'b0;
      @(negedge clk);
      chk("R1 idle", {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0086));
      repeat (3) @(negedge clk);
      chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R1 reset off",   {16'd0, eff_off}, 32'd0);
      chk("R1 reset phys",  {12'd0, phys_addr}, 32'd0);
      chk("R1 reset seg",   {30'd0, seg_id}, 32'd0);
      rst = 1'b0;
      @(negedge clk);

      // R11 worked case: DS 5000h, direct 4321h
      seg_ds = 16'h5000; mode = 3'd0; disp = 16'h4321; disp_wide = 1'b0;
      apply("R2 direct");
      chk("R11 54321", {12'd0, phys_addr}, 32'h54321);
      // R5 short displacement: 80h -> FF80h, high byte junk ignored
      mode = 3'd2; ptr_sel = 2'd2; reg_si = 16'h0100; disp = 16'hAB80; disp_wide = 1'b0;
      apply("R5 short neg");
      chk("R5 value", {16'd0, eff_off}, 32'h0080);
      disp = 16'h127F; apply("R5 short pos");
      chk("R5 value pos", {16'd0, eff_off}, 32'h017F);
      // R8 offset wrap
      mode = 3'd4; base_sel = 1'b1; idx_sel = 1'b1; reg_bp = 16'hFFF0;
      reg_di = 16'h0020; disp = 16'h0004; disp_wide = 1'b1; seg_ss = 16'h1234;
      apply("R8 wrap");
      chk("R8 value", {16'd0, eff_off}, 32'h0014);
      // R11 20-bit wrap via override to ES
      mode = 3'd3; base_sel = 1'b0; idx_sel = 1'b0; reg_bx = 16'h0010; reg_si = 16'h0000;
      seg_es = 16'hFFFF; ovr_en = 1'b1; ovr_seg = 2'd0;
      apply("R6 pair");
      chk("R11 wrap", {12'd0, phys_addr}, 32'h00000);
      chk("R10 es", {30'd0, seg_id}, 32'd0);
      ovr_en = 1'b0;
      // R3 BP indirect defaults to SS
      mode = 3'd1; ptr_sel = 2'd1; apply("R3 bp");
      chk("R9 ss", {30'd0, seg_id}, 32'd2);
      // unused mode code behaves as direct
      mode = 3'd6; disp = 16'hBEEF; apply("R2 code6");
      idle();

      for (int i = 0; i < 3000; i++) begin
         mode = 3'($urandom_range(0, 7));
         ptr_sel = 2'($urandom); base_sel = 1'($urandom); idx_sel = 1'($urandom);
         disp = 16'($urandom); disp_wide = 1'($urandom);
         ovr_en = ($urandom_range(0, 3) == 0); ovr_seg = 2'($urandom);
         reg_bx = 16'($urandom); reg_bp = 16'($urandom);
         reg_si = 16'($urandom); reg_di = 16'($urandom);
         seg_es = 16'($urandom); seg_cs = 16'($urandom);
         seg_ss = 16'($urandom); seg_ds = 16'($urandom);
         apply(mode_tag());
         if ($urandom_range(0, 7) == 0) idle();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule